// File: doc/BRIEF.md
# Cluster Candidate Finder

This block examines one 2x2 group of calorimeter towers per sample and decides whether the group carries a useful particle deposit. Each tower arrives as a 17-bit record holding an electromagnetic energy, a hadronic energy and a finegrain flag. The block adds the two energies of each tower and compares each sum with a programmable threshold, which gives one occupancy bit per tower. The 4-bit occupancy pattern then indexes a programmable 16-entry accept mask. An accepted group produces a 38-bit cluster word. The word carries the four tower energies, the OR of the finegrain flags and an electron/photon compatibility flag. A rejected group produces a word of all zeros. Neighbouring instances see windows that overlap by one tower.

The compatibility flag is read from a reloadable 256-entry one-bit table. Its address is built from the high bits of the summed electromagnetic and hadronic energies of the group. Every sample reads the table in one fixed pipeline cycle, so a reload must not land in that cycle. A two-state controller ensures this. In `EG_IDLE`, a table write commits at once when no lookup is in progress. If a lookup is in progress, the write is parked and the controller moves `EG_IDLE -> EG_HOLD`. In `EG_HOLD`, the parked write commits in the first cycle without a lookup, and the controller returns `EG_HOLD -> EG_IDLE`. Table writes that arrive during `EG_HOLD` are discarded. The result appears a fixed nine cycles after the sample.

Top module: `cluster_cand_finder`

## Requirements
- R1: A sample presented with `in_valid` high in cycle t produces `out_valid` high in cycle t+9, and in no other cycle. `out_word` is zero whenever `out_valid` is low.
- R2: Tower k occupies `in_towers[17k+16:17k]`, with the electromagnetic energy in bits [7:0], the hadronic energy in bits [15:8] and the finegrain flag in bit 16. The tower energy is their 9-bit sum, which never wraps (maximum 510).
- R3: The occupancy bit of tower k is 1 exactly when the tower energy is greater than or equal to the 9-bit threshold, with the equal case counting as occupied.
- R4: The pattern {b3,b2,b1,b0} indexes the accept mask. When that mask entry is 0, the valid output word is all zeros.
- R5: An accepted word is laid out as bit 37 = OR of the four finegrain flags, bit 36 = compatibility flag, and bits [9k+8:9k] = energy of tower k.
- R6: The compatibility flag equals the table entry at the address {Esum[9:6], Hsum[9:6]}. Esum and Hsum are the 10-bit sums of the four electromagnetic and the four hadronic energies.
- R7: Writes use `cfg_sel` 0 to load the threshold from `cfg_wdata[8:0]`, 1 to load mask entry `cfg_addr[3:0]` from `cfg_wdata[0]`, and 2 to load table entry `cfg_addr` from `cfg_wdata[0]`. With `cfg_sel` 3 the write changes nothing.
- R8: A sample from cycle t reads the threshold, mask and table in cycle t+2. A table write presented in cycle w commits at the end of the first cycle at or after w in which no sample reads the table.
- R9: A table write presented while an earlier table write is still parked is discarded.
- R10: After reset, the threshold is 0, all mask entries are 0, all table entries are 0, both outputs are 0 and the controller is in `EG_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A group is presented this cycle |
| in_towers | input | 68 | Four 17-bit tower records, tower 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 threshold, 1 mask, 2 table, 3 none |
| cfg_addr | input | 8 | Mask index or table address |
| cfg_wdata | input | 9 | Write data |
| out_valid | output | 1 | Cluster word is valid |
| out_word | output | 38 | Cluster word |

## Verification
Directed groups sit exactly on the threshold and one count below it, which separates `>=` from `>`. A single occupancy pattern is accepted while its neighbours are rejected, which exposes a swapped index bit. Saturated towers (255+255) catch a truncated sum. Groups with chosen energy totals hit specific table addresses, so the field order of the address shows up. Finegrain flags are set on single towers so that the OR and the field positions can be seen. Streaming runs with table writes placed around the lookup cycle, including back-to-back writes, separate an immediate commit from a parked one and from a discarded one. A long constrained-random stream with interleaved writes of every kind, including the ignored selector, is then compared against a bench model of all three configuration stores.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
    parameter int unsigned N_TWR     = 4;
    parameter int unsigned ET_W      = 8;
    parameter int unsigned TWR_W     = 2 * ET_W + 1;
    parameter int unsigned E_W       = ET_W + 1;
    parameter int unsigned CSUM_W    = ET_W + $clog2(N_TWR);
    parameter int unsigned OUT_W     = N_TWR * E_W + 2;
    parameter int unsigned TBL_HALF  = 4;
    parameter int unsigned TBL_AW    = 2 * TBL_HALF;
    parameter int unsigned TBL_N     = 1 << TBL_AW;
    parameter int unsigned PAT_N     = 1 << N_TWR;
    parameter int unsigned CFG_AW    = TBL_AW;
    parameter int unsigned CFG_DW    = E_W;

    typedef enum logic [1:0] {
        SEL_THR  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_EG   = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        EG_IDLE = 1'b0,
        EG_HOLD = 1'b1
    } eg_state_e;

    typedef struct packed {
        logic                    fg_or;
        logic                    eg;
        logic [N_TWR*E_W-1:0]    e;
    } clus_word_t;
endpackage

// File: rtl/ccf_cfg_regs.sv
module ccf_cfg_regs
    import ccf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_thr,
    input  logic [E_W-1:0]    thr_in,
    input  logic              wr_mask,
    input  logic [N_TWR-1:0]  mask_idx,
    input  logic              mask_bit,
    output logic [E_W-1:0]    thr,
    output logic [PAT_N-1:0]  mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr  <= '0;
            mask <= '0;
        end else begin
            if (wr_thr)  thr            <= thr_in;
            if (wr_mask) mask[mask_idx] <= mask_bit;
        end
    end
endmodule

// File: rtl/ccf_eg_table.sv
module ccf_eg_table
    import ccf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [TBL_AW-1:0]  wr_addr,
    input  logic               wr_bit,
    input  logic               rd_busy,
    input  logic [TBL_AW-1:0]  rd_addr,
    output logic               rd_bit,
    output eg_state_e          state_o,
    output logic               commit_o,
    output logic [TBL_AW-1:0]  pend_addr_o
);
    eg_state_e          state_q, state_d;
    logic [TBL_N-1:0]   tbl_q;
    logic [TBL_AW-1:0]  pend_addr_q, commit_addr;
    logic               pend_bit_q, commit_bit, pend_load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EG_IDLE;
        else        state_q <= state_d;
    end

    // next state and commit decisions
    always_comb begin
        state_d     = state_q;
        commit_o    = 1'b0;
        commit_addr = wr_addr;
        commit_bit  = wr_bit;
        pend_load   = 1'b0;
        unique case (state_q)
            EG_IDLE: begin
                if (wr_req) begin
                    if (rd_busy) begin
                        pend_load = 1'b1;
                        state_d   = EG_HOLD;
                    end else begin
                        commit_o  = 1'b1;
                    end
                end
            end
            EG_HOLD: begin
                if (!rd_busy) begin
                    commit_o    = 1'b1;
                    commit_addr = pend_addr_q;
                    commit_bit  = pend_bit_q;
                    state_d     = EG_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q       <= '0;
            pend_addr_q <= '0;
            pend_bit_q  <= 1'b0;
        end else begin
            if (commit_o) tbl_q[commit_addr] <= commit_bit;
            if (pend_load) begin
                pend_addr_q <= wr_addr;
                pend_bit_q  <= wr_bit;
            end
        end
    end

    assign rd_bit      = tbl_q[rd_addr];
    assign state_o     = state_q;
    assign pend_addr_o = pend_addr_q;
endmodule

// File: rtl/ccf_delay.sv
module ccf_delay #(
    parameter int unsigned W = 1,
    parameter int unsigned N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (N == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] st [N];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(N); i++) st[i] <= '0;
                end else begin
                    st[0] <= d;
                    for (int i = 1; i < int'(N); i++) st[i] <= st[i-1];
                end
            end
            assign q = st[N-1];
        end
    endgenerate
endmodule

// File: rtl/cluster_cand_finder.sv
module cluster_cand_finder
    import ccf_pkg::*;
#(
    parameter int unsigned LATENCY = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_TWR*TWR_W-1:0]   in_towers,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_word
);
    localparam int unsigned PAD = LATENCY - 3;

    // configuration decode
    cfg_sel_e sel_e;
    logic     wr_thr, wr_mask, wr_eg;
    assign sel_e   = cfg_sel_e'(cfg_sel);
    assign wr_thr  = cfg_we && (sel_e == SEL_THR);
    assign wr_mask = cfg_we && (sel_e == SEL_MASK);
    assign wr_eg   = cfg_we && (sel_e == SEL_EG);

    logic [E_W-1:0]   thr;
    logic [PAT_N-1:0] mask;

    ccf_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_thr   (wr_thr),
        .thr_in   (cfg_wdata),
        .wr_mask  (wr_mask),
        .mask_idx (cfg_addr[N_TWR-1:0]),
        .mask_bit (cfg_wdata[0]),
        .thr      (thr),
        .mask     (mask)
    );

    // stage 1: capture towers
    logic                   s1_v;
    logic [N_TWR*TWR_W-1:0] s1_twr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_twr <= '0;
        end else begin
            s1_v   <= in_valid;
            s1_twr <= in_towers;
        end
    end

    // stage 1 arithmetic: per-tower and per-group sums
    logic [E_W-1:0]    s1_e [N_TWR];
    logic [N_TWR-1:0]  s1_fg;
    logic [CSUM_W-1:0] s1_esum, s1_hsum;

    for (genvar k = 0; k < N_TWR; k++) begin : g_twr
        logic [ET_W-1:0] ecal, hcal;
        assign ecal     = s1_twr[k*TWR_W +: ET_W];
        assign hcal     = s1_twr[k*TWR_W + ET_W +: ET_W];
        assign s1_fg[k] = s1_twr[k*TWR_W + 2*ET_W];
        assign s1_e[k]  = {1'b0, ecal} + {1'b0, hcal};
    end

    always_comb begin
        s1_esum = '0;
        s1_hsum = '0;
        for (int k = 0; k < int'(N_TWR); k++) begin
            s1_esum = s1_esum + CSUM_W'(s1_twr[k*TWR_W +: ET_W]);
            s1_hsum = s1_hsum + CSUM_W'(s1_twr[k*TWR_W + ET_W +: ET_W]);
        end
    end

    // stage 2: sums registered, decision and table lookup
    logic              s2_v;
    logic [E_W-1:0]    s2_e [N_TWR];
    logic [N_TWR-1:0]  s2_fg;
    logic [CSUM_W-1:0] s2_esum, s2_hsum;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_fg   <= '0;
            s2_esum <= '0;
            s2_hsum <= '0;
            for (int k = 0; k < int'(N_TWR); k++) s2_e[k] <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_fg   <= s1_fg;
            s2_esum <= s1_esum;
            s2_hsum <= s1_hsum;
            for (int k = 0; k < int'(N_TWR); k++) s2_e[k] <= s1_e[k];
        end
    end

    logic [N_TWR-1:0]  pat;
    logic              hit;
    logic [TBL_AW-1:0] eg_addr;
    logic              eg_bit;
    clus_word_t        s2_word;

    always_comb begin
        pat = '0;
        for (int k = 0; k < int'(N_TWR); k++) pat[k] = (s2_e[k] >= thr);
    end
    assign hit     = mask[pat];
    assign eg_addr = {s2_esum[CSUM_W-1 -: TBL_HALF], s2_hsum[CSUM_W-1 -: TBL_HALF]};

    eg_state_e         eg_state;
    logic              eg_commit;
    logic [TBL_AW-1:0] eg_pend_addr;

    ccf_eg_table u_eg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_eg),
        .wr_addr     (cfg_addr),
        .wr_bit      (cfg_wdata[0]),
        .rd_busy     (s2_v),
        .rd_addr     (eg_addr),
        .rd_bit      (eg_bit),
        .state_o     (eg_state),
        .commit_o    (eg_commit),
        .pend_addr_o (eg_pend_addr)
    );

    always_comb begin
        s2_word = '0;
        if (s2_v && hit) begin
            s2_word.fg_or = |s2_fg;
            s2_word.eg    = eg_bit;
            for (int k = 0; k < int'(N_TWR); k++) s2_word.e[k*E_W +: E_W] = s2_e[k];
        end
    end

    // stage 3: registered cluster word
    logic             s3_v;
    logic [OUT_W-1:0] s3_word;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_word <= '0;
        end else begin
            s3_v    <= s2_v;
            s3_word <= s2_word;
        end
    end

    // latency padding
    logic [OUT_W:0] pad_d, pad_q;
    assign pad_d = {s3_v, s3_word};

    ccf_delay #(.W(OUT_W + 1), .N(PAD)) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_d),
        .q     (pad_q)
    );

    assign out_valid = pad_q[OUT_W];
    assign out_word  = pad_q[OUT_W-1:0];
endmodule

// File: rtl/ccf_checker.sv
module ccf_checker
    import ccf_pkg::*;
#(
    parameter int unsigned LATENCY = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_word,
    input logic              rd_busy,
    input eg_state_e         eg_state,
    input logic              eg_commit,
    input logic [TBL_AW-1:0] eg_pend_addr
);
    logic [LATENCY-1:0] vh;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vh <= '0;
        else        vh <= {vh[LATENCY-2:0], in_valid};
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vh[LATENCY-1]);

    a_r1_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0));

    a_r8_no_commit_on_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        eg_commit |-> !rd_busy);

    a_r8_hold_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (eg_state == EG_HOLD && !rd_busy) |=> (eg_state == EG_IDLE));

    a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eg_state == EG_HOLD && rd_busy) |=> (eg_state == EG_HOLD && $stable(eg_pend_addr)));
endmodule

bind cluster_cand_finder ccf_checker #(.LATENCY(LATENCY)) u_ccf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .rd_busy      (s2_v),
    .eg_state     (eg_state),
    .eg_commit    (eg_commit),
    .eg_pend_addr (eg_pend_addr)
);

// File: tb/cluster_cand_finder_test.sv
module cluster_cand_finder_test;
    localparam int CLK_P = 10;
    localparam int LAT   = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [67:0] in_towers = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_addr = '0;
    logic [8:0]  cfg_wdata = '0;
    logic        out_valid;
    logic [37:0] out_word;

    always #(CLK_P/2) clk = ~clk;

    cluster_cand_finder #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_towers(in_towers),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_word(out_word)
    );

    int    nchk = 0;
    int    nerr = 0;
    int    n = 0;
    bit    done = 0;
    string cur_req = "R10";

    // bench model of configuration stores
    logic [8:0]  m_thr = '0;
    logic        m_mask [16];
    logic        m_tbl [256];
    logic        m_pend = 1'b0;
    logic [7:0]  m_pa = '0;
    logic        m_pb = 1'b0;

    // sample and expectation rings indexed by cycle
    logic        sv [16];
    logic [67:0] sd [16];
    logic        ev [16];
    logic [37:0] ew [16];

    function automatic logic [16:0] twr(input logic fg, input logic [7:0] h, input logic [7:0] e);
        return {fg, h, e};
    endfunction

    function automatic logic [37:0] expect_word(input logic [67:0] t);
        logic [3:0]  pat;
        logic [9:0]  es, hs;
        logic        fo;
        logic [35:0] en;
        logic [8:0]  e;
        logic [7:0]  ec, hc;
        es = '0; hs = '0; fo = 1'b0; en = '0; pat = '0;
        for (int k = 0; k < 4; k++) begin
            ec = t[17*k +: 8];
            hc = t[17*k+8 +: 8];
            e  = {1'b0, ec} + {1'b0, hc};
            pat[k] = (e >= m_thr);
            en[9*k +: 9] = e;
            es = es + {2'b00, ec};
            hs = hs + {2'b00, hc};
            fo = fo | t[17*k+16];
        end
        if (!m_mask[pat]) return '0;
        return {fo, m_tbl[{es[9:6], hs[9:6]}], en};
    endfunction

    task automatic check_out();
        int s = n % 16;
        nchk++;
        if (out_valid !== ev[s] || out_word !== ew[s]) begin
            nerr++;
            $display("FAIL %s cycle %0d: got valid=%b word=%h, expected valid=%b word=%h",
                     cur_req, n, out_valid, out_word, ev[s], ew[s]);
        end
        ev[s] = 1'b0;
        ew[s] = '0;
    endtask

    // model of one cycle, applied after the inputs for cycle n are set
    task automatic model_cycle();
        int  s2 = (n + 14) % 16;
        logic busy = sv[s2];
        if (busy) begin
            ev[(n + LAT - 2) % 16] = 1'b1;
            ew[(n + LAT - 2) % 16] = expect_word(sd[s2]);
        end
        if (m_pend) begin
            if (!busy) begin
                m_tbl[m_pa] = m_pb;
                m_pend = 1'b0;
            end
        end else if (cfg_we && cfg_sel == 2'd2) begin
            if (busy) begin
                m_pend = 1'b1; m_pa = cfg_addr; m_pb = cfg_wdata[0];
            end else begin
                m_tbl[cfg_addr] = cfg_wdata[0];
            end
        end
        if (cfg_we && cfg_sel == 2'd0) m_thr = cfg_wdata;
        if (cfg_we && cfg_sel == 2'd1) m_mask[cfg_addr[3:0]] = cfg_wdata[0];
        sv[n % 16] = in_valid;
        sd[n % 16] = in_towers;
    endtask

    task automatic step(input logic v, input logic [67:0] t, input logic we,
                        input logic [1:0] sel, input logic [7:0] a, input logic [8:0] d);
        @(negedge clk);
        check_out();
        in_valid = v; in_towers = t;
        cfg_we = we; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
        model_cycle();
        n++;
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) step(1'b0, '0, 1'b0, 2'd0, 8'd0, 9'd0);
    endtask

    task automatic sample(input logic [67:0] t);
        step(1'b1, t, 1'b0, 2'd0, 8'd0, 9'd0);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] a, input logic [8:0] d);
        step(1'b0, '0, 1'b1, sel, a, d);
    endtask

    // a group whose sums land on table address {ea,ha}
    function automatic logic [67:0] at_addr(input logic [3:0] ea, input logic [3:0] ha, input logic [3:0] fg);
        logic [7:0] ec = {ea, 4'h0};
        logic [7:0] hc = {ha, 4'h0};
        return {twr(fg[3], hc, ec), twr(fg[2], hc, ec), twr(fg[1], hc, ec), twr(fg[0], hc, ec)};
    endfunction

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        for (int i = 0; i < 16; i++) begin
            sv[i] = 1'b0; sd[i] = '0; ev[i] = 1'b0; ew[i] = '0; m_mask[i] = 1'b0;
        end
        for (int i = 0; i < 256; i++) m_tbl[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state at the ports
        nchk++;
        if (out_valid !== 1'b0 || out_word !== '0) begin
            nerr++;
            $display("FAIL R10 reset: got valid=%b word=%h, expected 0 0", out_valid, out_word);
        end
        cur_req = "R10";
        sample(at_addr(4'd0, 4'd0, 4'hF));   // zero mask: all-zero word
        idle(10);

        // R3 / R4: threshold boundary, one accepted pattern
        cur_req = "R3";
        cfg(2'd0, 8'd0, 9'd100);
        cfg(2'd1, 8'd5, 9'd1);               // pattern 0101 accepted
        sample({twr(1'b0, 8'd0, 8'd0), twr(1'b0, 8'd0, 8'd100),
                twr(1'b0, 8'd50, 8'd49), twr(1'b1, 8'd40, 8'd60)});
        cur_req = "R4";
        sample({twr(1'b0, 8'd0, 8'd0), twr(1'b0, 8'd0, 8'd100),
                twr(1'b0, 8'd50, 8'd49), twr(1'b1, 8'd40, 8'd59)});
        sample({twr(1'b0, 8'd0, 8'd0), twr(1'b0, 8'd0, 8'd100),
                twr(1'b0, 8'd50, 8'd50), twr(1'b1, 8'd40, 8'd60)});
        idle(10);

        // R2 / R5: saturated towers, finegrain on single towers
        cur_req = "R2";
        cfg(2'd1, 8'd15, 9'd1);
        sample({4{twr(1'b0, 8'd255, 8'd255)}});
        cur_req = "R5";
        sample({twr(1'b1, 8'd200, 8'd1), twr(1'b0, 8'd120, 8'd7),
                twr(1'b0, 8'd101, 8'd3), twr(1'b0, 8'd255, 8'd0)});
        sample({twr(1'b0, 8'd200, 8'd1), twr(1'b0, 8'd120, 8'd7),
                twr(1'b0, 8'd101, 8'd3), twr(1'b0, 8'd255, 8'd0)});
        idle(10);

        // R6: table addressing by field
        cur_req = "R6";
        cfg(2'd0, 8'd0, 9'd0);
        cfg(2'd2, 8'h3A, 9'd1);
        sample(at_addr(4'h3, 4'hA, 4'h2));
        sample(at_addr(4'hA, 4'h3, 4'h0));
        idle(10);

        // R7: ignored selector and full-width threshold
        cur_req = "R7";
        cfg(2'd3, 8'h3A, 9'd0);
        cfg(2'd3, 8'd15, 9'd0);
        sample(at_addr(4'h3, 4'hA, 4'h0));
        cfg(2'd0, 8'd0, 9'd300);
        cfg(2'd1, 8'd0, 9'd1);
        sample({4{twr(1'b0, 8'd150, 8'd149)}});
        sample({4{twr(1'b0, 8'd150, 8'd150)}});
        cfg(2'd0, 8'd0, 9'd0);
        idle(10);

        // program mask and table with idle writes
        cur_req = "R7";
        for (int i = 0; i < 16; i++) cfg(2'd1, 8'(i), 9'($urandom % 2));
        cfg(2'd1, 8'd15, 9'd1);
        for (int i = 0; i < 256; i++) cfg(2'd2, 8'(i), 9'($urandom % 2));

        // R8: write during streaming is parked until a gap
        cur_req = "R8";
        cfg(2'd2, 8'h55, 9'd0);
        sample(at_addr(4'h5, 4'h5, 4'h0));
        sample(at_addr(4'h5, 4'h5, 4'h0));
        step(1'b1, at_addr(4'h5, 4'h5, 4'h0), 1'b1, 2'd2, 8'h55, 9'd1);
        sample(at_addr(4'h5, 4'h5, 4'h0));
        sample(at_addr(4'h5, 4'h5, 4'h0));
        idle(3);
        sample(at_addr(4'h5, 4'h5, 4'h0));
        idle(10);

        // R9: second write while one is parked is dropped
        cur_req = "R9";
        cfg(2'd2, 8'h66, 9'd0);
        cfg(2'd2, 8'h77, 9'd0);
        sample(at_addr(4'h1, 4'h1, 4'h0));
        sample(at_addr(4'h1, 4'h1, 4'h0));
        step(1'b1, at_addr(4'h1, 4'h1, 4'h0), 1'b1, 2'd2, 8'h66, 9'd1);
        step(1'b1, at_addr(4'h1, 4'h1, 4'h0), 1'b1, 2'd2, 8'h77, 9'd1);
        idle(4);
        sample(at_addr(4'h6, 4'h6, 4'h0));
        sample(at_addr(4'h7, 4'h7, 4'h0));
        idle(12);

        // R1: constrained-random stream with interleaved writes
        cur_req = "R1";
        for (int i = 0; i < 4000; i++) begin
            logic [67:0] t;
            logic        we;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ec = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 64);
                logic [7:0] hc = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 64);
                t[17*k +: 17] = twr(1'($urandom % 2), hc, ec);
            end
            we = ($urandom % 6 == 0);
            step(1'($urandom % 4 != 0), t, we, 2'($urandom % 4), 8'($urandom % 256),
                 9'($urandom % 128));
        end
        idle(14);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule